// File: doc/BRIEF.md
# Trap State Return Unpacker

This block carries out the two return-from-trap sequences of a processor core. The caller presents a saved 64-bit trap-state word, the saved trap PC and next-PC, the current trap level and a flag that selects between the two flavours. One cycle later the block presents the restored program counters, condition codes, address-space identifier, processor-state field, internal window index and global level, along with a trap level one lower than the input.

The "done" flavour resumes after the trapped instruction. The "retry" flavour re-executes it. The architectural window number held in the trap-state word is folded into the configured window count. It is then turned into a reversed internal index, so that architectural window 0 maps to the highest internal slot. A request made at trap level zero has nothing to return from. It is refused with a one-cycle error pulse and leaves every output as it was.

Top module: `trap_return_unpacker`

## Requirements
- R1: After reset every data output is zero and both result strobes are low.
- R2: For a done request (reqRetry = 0), pcOut becomes savedNpc and npcOut becomes savedNpc + 4, wrapping modulo 2^PC_W.
- R3: For a retry request (reqRetry = 1), pcOut becomes savedPc and npcOut becomes savedNpc.
- R4: ccrOut takes trapState[39:32]: the upper nibble holds the extended condition codes and the lower nibble holds the integer condition codes.
- R5: asiOut takes trapState[31:24].
- R6: pstateOut takes trapState[19:8] ANDed with 12'hF3F, so bits 7:6 are always cleared.
- R7: cwpOut equals WIN_COUNT - 1 - (trapState[7:0] mod WIN_COUNT). An out-of-range window number is reduced before this reversal.
- R8: With HV_EN = 1, glOut takes trapState[42:40]. With HV_EN = 0, glOut stays zero.
- R9: An accepted request sets trapLevelOut to trapLevelIn - 1.
- R10: A request with trapLevelIn = 0 pulses errStrobe for one cycle, does not pulse updValid, and leaves every data output unchanged.
- R11: An accepted request updates all data outputs together on the next rising clock edge and pulses updValid for exactly that cycle. When there is no accepted request, the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Return request for this cycle |
| reqRetry | input | 1 | 1 selects retry, 0 selects done |
| trapState | input | 64 | Saved trap-state word |
| savedPc | input | PC_W | Saved trap PC |
| savedNpc | input | PC_W | Saved trap next-PC |
| trapLevelIn | input | TL_W | Current trap level |
| pcOut | output | PC_W | Restored PC |
| npcOut | output | PC_W | Restored next-PC |
| ccrOut | output | 8 | Restored condition codes |
| asiOut | output | 8 | Restored address-space identifier |
| pstateOut | output | 12 | Restored processor state |
| cwpOut | output | $clog2(WIN_COUNT) | Internal (reversed) window index |
| glOut | output | 3 | Restored global level |
| trapLevelOut | output | TL_W | Decremented trap level |
| updValid | output | 1 | One-cycle pulse marking a completed return |
| errStrobe | output | 1 | One-cycle pulse marking a refused request at level zero |

## Verification
Several behaviours are checked by assertions on every clock cycle:
- the choice between the accept pulse and the refuse pulse,
- that outputs do not move without a load,
- the next-PC increment for done and the PC source for retry,
- the trap-level decrement,
- that the window index stays below the window count.

Other behaviours can only be shown by the bench's scenarios. These are the exact bit-field extraction, the processor-state mask, the modulo folding of large window numbers (255, 7, 4, 0 with five windows), the next-PC wrap at all-ones, and a refused request arriving right after the level reaches zero. The bench checks them against a model built from the requirements.

// File: rtl/trp_pkg.sv
package trp_pkg;
  typedef struct packed {
    logic load;
    logic retry;
  } trpStrobe_t;
endpackage

// File: rtl/trp_ctrl.sv
module trp_ctrl #(
  parameter int TL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqRetry,
  input  logic [TL_W-1:0]   trapLevelIn,
  output trp_pkg::trpStrobe_t strb,
  output logic              updValid,
  output logic              errStrobe
);
  logic atFloor;
  assign atFloor    = (trapLevelIn == '0);
  assign strb.load  = reqValid && !atFloor;
  assign strb.retry = reqRetry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      updValid  <= 1'b0;
      errStrobe <= 1'b0;
    end else begin
      updValid  <= reqValid && !atFloor;
      errStrobe <= reqValid && atFloor;
    end
  end

  // R10
  refuse_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && trapLevelIn == '0) |=> (errStrobe && !updValid));

  // R11
  accept_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && trapLevelIn != '0) |=> (updValid && !errStrobe));

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> (!updValid && !errStrobe));
endmodule

// File: rtl/trp_datapath.sv
module trp_datapath #(
  parameter int PC_W      = 64,
  parameter int WIN_COUNT = 8,
  parameter int TL_W      = 3,
  parameter bit HV_EN     = 1'b1,
  localparam int CWP_W    = $clog2(WIN_COUNT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  trp_pkg::trpStrobe_t strb,
  input  logic [63:0]         trapState,
  input  logic [PC_W-1:0]     savedPc,
  input  logic [PC_W-1:0]     savedNpc,
  input  logic [TL_W-1:0]     trapLevelIn,
  output logic [PC_W-1:0]     pcOut,
  output logic [PC_W-1:0]     npcOut,
  output logic [7:0]          ccrOut,
  output logic [7:0]          asiOut,
  output logic [11:0]         pstateOut,
  output logic [CWP_W-1:0]    cwpOut,
  output logic [2:0]          glOut,
  output logic [TL_W-1:0]     trapLevelOut
);
  localparam logic [7:0]  NWIN8     = 8'(WIN_COUNT);
  localparam logic [11:0] PST_MASK  = 12'hF3F;

  // field decode of the trap-state word
  logic [7:0]      archWin;
  logic [7:0]      foldedWin;
  logic [CWP_W-1:0] cwpNext;
  logic [PC_W-1:0] pcNext;
  logic [PC_W-1:0] npcNext;

  assign archWin   = trapState[7:0];
  assign foldedWin = (archWin >= NWIN8) ? (archWin % NWIN8) : archWin;
  assign cwpNext   = CWP_W'(NWIN8 - 8'd1 - foldedWin);
  assign pcNext    = strb.retry ? savedPc  : savedNpc;
  assign npcNext   = strb.retry ? savedNpc : savedNpc + PC_W'(4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcOut        <= '0;
      npcOut       <= '0;
      ccrOut       <= '0;
      asiOut       <= '0;
      pstateOut    <= '0;
      cwpOut       <= '0;
      trapLevelOut <= '0;
    end else if (strb.load) begin
      pcOut        <= pcNext;
      npcOut       <= npcNext;
      ccrOut       <= trapState[39:32];
      asiOut       <= trapState[31:24];
      pstateOut    <= trapState[19:8] & PST_MASK;
      cwpOut       <= cwpNext;
      trapLevelOut <= trapLevelIn - TL_W'(1);
    end
  end

  generate
    if (HV_EN) begin : g_gl
      always_ff @(posedge clk) begin
        if (!rst_n)          glOut <= '0;
        else if (strb.load)  glOut <= trapState[42:40];
      end
    end else begin : g_nogl
      assign glOut = '0;
    end
  endgenerate

  // R11
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.load |=> ($stable(pcOut) && $stable(npcOut) && $stable(cwpOut) && $stable(trapLevelOut)));

  // R2
  done_npc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.load && !strb.retry) |=> (npcOut == $past(savedNpc) + PC_W'(4) && pcOut == $past(savedNpc)));

  // R3
  retry_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.load && strb.retry) |=> (pcOut == $past(savedPc) && npcOut == $past(savedNpc)));

  // R9
  tl_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> (trapLevelOut == $past(trapLevelIn) - TL_W'(1)));

  // R7
  cwp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> (32'(cwpOut) < WIN_COUNT));
endmodule

// File: rtl/trap_return_unpacker.sv
module trap_return_unpacker #(
  parameter int PC_W      = 64,
  parameter int WIN_COUNT = 8,
  parameter int TL_W      = 3,
  parameter bit HV_EN     = 1'b1,
  localparam int CWP_W    = $clog2(WIN_COUNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             reqRetry,
  input  logic [63:0]      trapState,
  input  logic [PC_W-1:0]  savedPc,
  input  logic [PC_W-1:0]  savedNpc,
  input  logic [TL_W-1:0]  trapLevelIn,
  output logic [PC_W-1:0]  pcOut,
  output logic [PC_W-1:0]  npcOut,
  output logic [7:0]       ccrOut,
  output logic [7:0]       asiOut,
  output logic [11:0]      pstateOut,
  output logic [CWP_W-1:0] cwpOut,
  output logic [2:0]       glOut,
  output logic [TL_W-1:0]  trapLevelOut,
  output logic             updValid,
  output logic             errStrobe
);
  trp_pkg::trpStrobe_t strb;

  trp_ctrl #(.TL_W(TL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqRetry(reqRetry),
    .trapLevelIn(trapLevelIn), .strb(strb), .updValid(updValid), .errStrobe(errStrobe)
  );

  trp_datapath #(.PC_W(PC_W), .WIN_COUNT(WIN_COUNT), .TL_W(TL_W), .HV_EN(HV_EN)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .trapState(trapState),
    .savedPc(savedPc), .savedNpc(savedNpc), .trapLevelIn(trapLevelIn),
    .pcOut(pcOut), .npcOut(npcOut), .ccrOut(ccrOut), .asiOut(asiOut),
    .pstateOut(pstateOut), .cwpOut(cwpOut), .glOut(glOut), .trapLevelOut(trapLevelOut)
  );
endmodule

// File: tb/trap_return_unpacker_tb.sv
module trap_return_unpacker_tb;
  localparam int NWIN = 5;
  localparam int CW   = $clog2(NWIN);

  typedef struct {
    bit          isErr;
    logic [63:0] pc;
    logic [63:0] npc;
    logic [7:0]  ccr;
    logic [7:0]  asi;
    logic [11:0] pst;
    logic [CW-1:0] cwp;
    logic [2:0]  gl;
    logic [2:0]  tl;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic reqRetry = 1'b0;
  logic [63:0] trapState = '0;
  logic [63:0] savedPc = '0;
  logic [63:0] savedNpc = '0;
  logic [2:0]  trapLevelIn = '0;
  logic [63:0] pcOut, npcOut;
  logic [7:0]  ccrOut, asiOut;
  logic [11:0] pstateOut;
  logic [CW-1:0] cwpOut;
  logic [2:0]  glOut, trapLevelOut;
  logic updValid, errStrobe;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;
  bit finished = 1'b0;
  exp_t scoreQ[$];
  exp_t held;
  exp_t predicted;

  always #2.5 clk = ~clk;

  trap_return_unpacker #(.PC_W(64), .WIN_COUNT(NWIN), .TL_W(3), .HV_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqRetry(reqRetry),
    .trapState(trapState), .savedPc(savedPc), .savedNpc(savedNpc),
    .trapLevelIn(trapLevelIn), .pcOut(pcOut), .npcOut(npcOut), .ccrOut(ccrOut),
    .asiOut(asiOut), .pstateOut(pstateOut), .cwpOut(cwpOut), .glOut(glOut),
    .trapLevelOut(trapLevelOut), .updValid(updValid), .errStrobe(errStrobe)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compOut(input exp_t e, input string ctx);
    chk(pcOut == e.pc,         {ctx, " R2/R3 pc"},  pcOut, e.pc);
    chk(npcOut == e.npc,       {ctx, " R2/R3 npc"}, npcOut, e.npc);
    chk(ccrOut == e.ccr,       {ctx, " R4 ccr"},    64'(ccrOut), 64'(e.ccr));
    chk(asiOut == e.asi,       {ctx, " R5 asi"},    64'(asiOut), 64'(e.asi));
    chk(pstateOut == e.pst,    {ctx, " R6 pstate"}, 64'(pstateOut), 64'(e.pst));
    chk(cwpOut == e.cwp,       {ctx, " R7 cwp"},    64'(cwpOut), 64'(e.cwp));
    chk(glOut == e.gl,         {ctx, " R8 gl"},     64'(glOut), 64'(e.gl));
    chk(trapLevelOut == e.tl,  {ctx, " R9 tl"},     64'(trapLevelOut), 64'(e.tl));
  endtask

  // driver: called right after a falling edge; holds the request for one cycle
  task automatic sendReq(input bit retry, input logic [63:0] ts, input logic [63:0] pc,
                         input logic [63:0] npc, input logic [2:0] tl);
    exp_t e;
    int folded;
    if (tl == 3'd0) begin
      e = predicted;
      e.isErr = 1'b1;               // R10: state unchanged
    end else begin
      e.isErr = 1'b0;
      e.pc  = retry ? pc  : npc;
      e.npc = retry ? npc : npc + 64'd4;
      e.ccr = ts[39:32];
      e.asi = ts[31:24];
      e.pst = ts[19:8] & 12'hF3F;
      folded = int'(ts[7:0]) % NWIN;
      e.cwp = CW'(NWIN - 1 - folded);
      e.gl  = ts[42:40];
      e.tl  = tl - 3'd1;
      predicted = e;
    end
    scoreQ.push_back(e);
    reqValid = 1'b1; reqRetry = retry; trapState = ts;
    savedPc = pc; savedNpc = npc; trapLevelIn = tl;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (running) begin
      if (updValid || errStrobe) begin
        if (scoreQ.size() == 0) begin
          chk(1'b0, "R11 unexpected strobe", 64'(updValid), 64'd0);
        end else begin
          exp_t e;
          e = scoreQ.pop_front();
          chk(errStrobe == e.isErr && updValid == !e.isErr, "R10/R11 strobe kind",
              64'({updValid, errStrobe}), 64'({!e.isErr, e.isErr}));
          compOut(e, e.isErr ? "R10 refused" : "R11 result");
          held = e;
        end
      end else begin
        compOut(held, "R11 hold");
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    held = '{isErr: 1'b0, pc: '0, npc: '0, ccr: '0, asi: '0, pst: '0, cwp: '0, gl: '0, tl: '0};
    predicted = held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(updValid == 1'b0 && errStrobe == 1'b0, "R1 strobes", 64'({updValid, errStrobe}), 64'd0);
    compOut(held, "R1 reset");
    running = 1'b1;

    // done: ccr A5, asi 80, pstate all ones, arch window 1, gl 5
    sendReq(1'b0, 64'h0000_05A5_80FF_FF01, 64'h1000, 64'h1004, 3'd3);
    @(negedge clk);
    // retry, arch window 7 folds to 2
    sendReq(1'b1, 64'h0000_023C_1200_0007, 64'h2000, 64'h2008, 3'd2);
    @(negedge clk);
    // R10: level zero is refused
    sendReq(1'b0, 64'h0000_07FF_FFFF_FFFF, 64'hDEAD, 64'hBEEF, 3'd0);
    @(negedge clk);
    // back-to-back, R7 window 255, 4, 0
    sendReq(1'b1, 64'h0000_0111_2233_44FF, 64'h3000, 64'h3004, 3'd7);
    sendReq(1'b0, 64'h0000_0622_3344_5504, 64'h4000, 64'h4010, 3'd5);
    sendReq(1'b1, 64'h0000_0333_4455_6600, 64'h5000, 64'h5004, 3'd4);
    // R9 level one then R10 at zero right behind it
    sendReq(1'b0, 64'h0000_0400_0000_0003, 64'h6000, 64'h6004, 3'd1);
    sendReq(1'b1, 64'h0000_0700_0000_0002, 64'h7000, 64'h7004, 3'd0);
    // R2 wrap of next-PC at all ones
    sendReq(1'b0, 64'h0000_0000_0000_0005, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 3'd6);
    repeat (3) @(negedge clk);
    // pseudo-random mix
    for (int i = 0; i < 40; i++) begin
      logic [63:0] v;
      v = 64'h9E37_79B9_7F4A_7C15 * 64'(i + 1);
      sendReq(v[0], v ^ 64'h5A5A_0000_1234_0000, v >> 3, v >> 5, v[45:43]);
      if (v[7]) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(scoreQ.size() == 0, "R11 all results seen", 64'(scoreQ.size()), 64'd0);
    running = 1'b0;
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule